// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This unit performs the arithmetic step of a 64-bit register machine. A caller presents a 4-bit operation code, a source-select bit, a width-class bit, the current destination value, a source register value and a 32-bit immediate. It then pulses `start_i`. The unit answers with the new destination value on `result_o` and a one-cycle `done_o` strobe.

The unit handles addition, subtraction and multiplication, the three bitwise logic operations, register move, and logical and arithmetic shifts in both directions. It also converts byte order. Unsigned division and remainder run on an iterative one-bit-per-cycle divider. `busy_o` is high while that divider runs. A zero divisor does not trap. It gives a fixed answer in a single cycle.

In the 32-bit class the unit works on the low halves of the operands and clears the upper half of the result. Register file, fetch, branches and memory are handled elsewhere.

Top module: `dual_alu`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `result_o` is zero and `done_o` and `busy_o` are low until the first operation completes.
- R2: `use_reg_i`=1 selects `src_i` as the second operand and `use_reg_i`=0 selects the immediate. With `wide_i`=1 the immediate is sign-extended from bit 31 to 64 bits. With `wide_i`=0 it is used as an unsigned 32-bit value.
- R3: The operation codes are add 0x0, sub 0x1 and mul 0x2. They wrap modulo 2^64, and mul returns the low 64 bits of the product.
- R4: With `wide_i`=0, every listed operation except byte conversion works on the low 32 bits of both operands. The result's upper 32 bits are zero.
- R5: The codes or 0x4, and 0x5 and xor 0xA are bitwise. Move 0xB returns the selected second operand.
- R6: Left shift 0x6, logical right shift 0x7 and arithmetic right shift 0xC take the shift amount from the second operand, masked to 6 bits (64-bit class) or 5 bits (32-bit class). Arithmetic shift replicates bit 63, or bit 31 in the 32-bit class.
- R7: For every operation except division and remainder with a nonzero divisor, `done_o` and the result appear right after the clock edge that samples `start_i`. `busy_o` stays low, and `done_o` lasts one cycle.
- R8: Divide 0x3 and remainder 0x9 are unsigned. With a nonzero divisor, `busy_o` is high from the launch edge until the result arrives. `done_o` rises together with the result exactly 64 edges (64-bit class) or 32 edges (32-bit class) after the launch edge, and `busy_o` falls at that same edge.
- R9: Division by zero returns 0. Remainder by zero returns the destination unchanged in the 64-bit class, or its low 32 bits zero-extended in the 32-bit class. Both complete in one cycle.
- R10: For an immediate divisor, the 32-bit class uses the immediate as unsigned. The 64-bit class sign-extends it and then divides unsigned.
- R11: Code 0xD converts the destination's byte order and ignores the source and the width class. An immediate of 16 or 32 selects that width, and any other value selects 64. `use_reg_i`=0 selects little-endian: truncate to the width and zero-extend. `use_reg_i`=1 selects big-endian: reverse the bytes within the width and zero-extend.
- R12: A `start_i` pulse while `busy_o` is high is ignored. The running division still delivers its own result at its own time.
- R13: The unlisted codes 0x8, 0xE and 0xF return the destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, sampled on the rising edge |
| op_i | input | 4 | Operation code |
| use_reg_i | input | 1 | 1: source register, 0: immediate; byte order for conversion |
| wide_i | input | 1 | 1: 64-bit class, 0: 32-bit class |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source register operand |
| imm_i | input | 32 | Immediate |
| result_o | output | 64 | New destination value, held until the next completion |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Iterative divider running |

## Verification
Some behaviours are checked by assertions on every cycle. Single-cycle operations must strobe `done_o` on the following cycle without raising `busy_o`. A 32-bit result must have a clear upper half. A zero divisor must yield zero at once. `done_o` and `busy_o` must never be high together, and `done_o` must be high whenever `busy_o` falls. A start seen while busy must not cut the division short. The remainder leaving the divider must be below the divisor.

Other behaviours need the directed scenarios in the bench. These are the exact numeric results: wrap-around, sign extension of the immediate, shift masking, and byte order at each width. They also cover the exact 32- and 64-edge divider latency and the unchanged result after an ignored start.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_SHL  = 4'h6;
  localparam logic [3:0] OP_SHR  = 4'h7;
  localparam logic [3:0] OP_MOD  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'hA;
  localparam logic [3:0] OP_MOV  = 4'hB;
  localparam logic [3:0] OP_SAR  = 4'hC;
  localparam logic [3:0] OP_SWAP = 4'hD;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_32 = 2'd1,
    SW_64 = 2'd2
  } swap_width_e;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/alu_bswap.sv
module alu_bswap
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            big_i,
  input  swap_width_e     width_i,
  output logic [XLEN-1:0] out_o
);
  localparam int NB = XLEN / 8;

  int nbytes;

  always_comb begin
    case (width_i)
      SW_16:   nbytes = 2;
      SW_32:   nbytes = 4;
      default: nbytes = NB;
    endcase
  end

  always_comb begin
    out_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (k < nbytes) begin
        if (big_i) begin
          out_o[8*k +: 8] = val_i[8*(nbytes-1-k) +: 8];
        end else begin
          out_o[8*k +: 8] = val_i[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/alu_iterdiv.sv
module alu_iterdiv
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic            busy_o,
  output logic            fin_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN) + 1;

  div_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [XLEN-1:0] dvd_q, dvd_d;
  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] rem_q, rem_d;
  logic [XLEN-1:0] dsr_q, dsr_d;

  logic [XLEN:0]   rem_sh;
  logic [XLEN:0]   diff;
  logic            ge;
  logic [XLEN-1:0] quo_step, rem_step;

  // one restoring step per cycle
  always_comb begin
    rem_sh   = {rem_q, dvd_q[XLEN-1]};
    diff     = rem_sh - {1'b0, dsr_q};
    ge       = ~diff[XLEN];
    rem_step = ge ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
    quo_step = {quo_q[XLEN-2:0], ge};
  end

  assign busy_o = (state_q == DIV_RUN);
  assign fin_o  = busy_o && (cnt_q == CW'(1));
  assign quo_o  = quo_step;
  assign rem_o  = rem_step;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dvd_d   = dvd_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    dsr_d   = dsr_q;
    if (state_q == DIV_IDLE) begin
      if (load_i) begin
        state_d = DIV_RUN;
        cnt_d   = wide_i ? CW'(XLEN) : CW'(HALF);
        dvd_d   = wide_i ? dividend_i : {dividend_i[HALF-1:0], {HALF{1'b0}}};
        quo_d   = '0;
        rem_d   = '0;
        dsr_d   = divisor_i;
      end
    end else begin
      dvd_d = {dvd_q[XLEN-2:0], 1'b0};
      quo_d = quo_step;
      rem_d = rem_step;
      cnt_d = cnt_q - CW'(1);
      if (fin_o) state_d = DIV_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      cnt_q   <= '0;
      dvd_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dsr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dvd_q   <= dvd_d;
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      dsr_q   <= dsr_d;
    end
  end

  // R8
  rem_below_divisor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> (rem_o < dsr_q));
endmodule

// File: rtl/dual_alu.sv
module dual_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [3:0]      op_i,
  input  logic            use_reg_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o,
  output logic            busy_o
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] imm_ext, opb, a_eff, b_eff, sar_src;
  logic [XLEN-1:0] raw, single_res, swap_out;
  logic [SHW-1:0]  shamt;
  logic            known_op, div_op, div_zero, launch, launch_div;
  swap_width_e     swap_w;

  logic            div_busy, div_fin;
  logic [XLEN-1:0] div_quo, div_rem;

  logic            mod_q, mod_d;
  logic            done_q, done_d;
  logic [XLEN-1:0] result_q, result_d;

  // operand shaping
  always_comb begin
    imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
    opb     = use_reg_i ? src_i : imm_ext;
    a_eff   = wide_i ? dst_i : {{HALF{1'b0}}, dst_i[HALF-1:0]};
    b_eff   = wide_i ? opb   : {{HALF{1'b0}}, opb[HALF-1:0]};
    sar_src = wide_i ? dst_i : {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]};
    shamt   = wide_i ? opb[SHW-1:0] : {1'b0, opb[SHW-2:0]};
    if (imm_i == IMMW'(16))      swap_w = SW_16;
    else if (imm_i == IMMW'(32)) swap_w = SW_32;
    else                         swap_w = SW_64;
  end

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_OR, OP_AND, OP_SHL, OP_SHR,
      OP_MOD, OP_XOR, OP_MOV, OP_SAR, OP_SWAP: known_op = 1'b1;
      default:                                 known_op = 1'b0;
    endcase
  end

  assign div_op     = (op_i == OP_DIV) || (op_i == OP_MOD);
  assign div_zero   = (b_eff == '0);
  assign launch     = start_i && !div_busy;
  assign launch_div = launch && div_op && !div_zero;

  alu_bswap #(.XLEN(XLEN)) bswap_i (
    .val_i   (dst_i),
    .big_i   (use_reg_i),
    .width_i (swap_w),
    .out_o   (swap_out)
  );

  alu_iterdiv #(.XLEN(XLEN)) div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (launch_div),
    .wide_i     (wide_i),
    .dividend_i (a_eff),
    .divisor_i  (b_eff),
    .busy_o     (div_busy),
    .fin_o      (div_fin),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  // single-cycle datapath
  always_comb begin
    case (op_i)
      OP_ADD:  raw = a_eff + b_eff;
      OP_SUB:  raw = a_eff - b_eff;
      OP_MUL:  raw = a_eff * b_eff;
      OP_OR:   raw = a_eff | b_eff;
      OP_AND:  raw = a_eff & b_eff;
      OP_XOR:  raw = a_eff ^ b_eff;
      OP_MOV:  raw = b_eff;
      OP_SHL:  raw = a_eff << shamt;
      OP_SHR:  raw = a_eff >> shamt;
      OP_SAR:  raw = $signed(sar_src) >>> shamt;
      OP_DIV:  raw = '0;
      OP_MOD:  raw = dst_i;
      default: raw = dst_i;
    endcase
    if (op_i == OP_SWAP)  single_res = swap_out;
    else if (!known_op)   single_res = dst_i;
    else if (wide_i)      single_res = raw;
    else                  single_res = {{HALF{1'b0}}, raw[HALF-1:0]};
  end

  // next state
  always_comb begin
    mod_d    = mod_q;
    done_d   = 1'b0;
    result_d = result_q;
    if (launch_div) mod_d = (op_i == OP_MOD);
    if (div_fin) begin
      done_d   = 1'b1;
      result_d = mod_q ? div_rem : div_quo;
    end else if (launch && !launch_div) begin
      done_d   = 1'b1;
      result_d = single_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= done_d;
      if (launch_div) mod_q <= mod_d;
      if (done_d) result_q <= result_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
  assign busy_o   = div_busy;

  // R7
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !(div_op && !div_zero)) |=> (done_o && !busy_o));

  // R4
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !wide_i && known_op && op_i != OP_SWAP && !div_op)
    |=> (result_o[XLEN-1:HALF] == '0));

  // R9
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == OP_DIV && div_zero) |=> (done_o && result_o == '0));

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R12
  ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !div_fin) |=> (busy_o && !done_o));
endmodule

// File: tb/dual_alu_tb_top.sv
module dual_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic        use_reg, wide;
  logic [63:0] dst, src;
  logic [31:0] imm;
  logic [63:0] result;
  logic        done, busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .use_reg_i(use_reg), .wide_i(wide), .dst_i(dst), .src_i(src),
    .imm_i(imm), .result_o(result), .done_o(done), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // launch one operation and check result and latency
  task automatic run_op(input logic [3:0] o, input logic r, input logic w,
                        input logic [63:0] d, input logic [63:0] s, input logic [31:0] i,
                        input logic [63:0] exp, input int exp_lat, input string tag);
    int lat;
    @(negedge clk);
    op = o; use_reg = r; wide = w; dst = d; src = s; imm = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    if (exp_lat > 0) chk(busy === 1'b1, {tag, " busy"}, 64'(busy), 64'd1);
    else             chk(busy === 1'b0, {tag, " busy"}, 64'(busy), 64'd0);
    while (done !== 1'b1 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(result === exp, tag, result, exp);
    chk(lat == exp_lat, {tag, " latency"}, 64'(lat), 64'(exp_lat));
    @(negedge clk);
    chk(done === 1'b0, {tag, " done pulse"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    // R1
    chk(result === 64'd0 && done === 1'b0 && busy === 1'b0, "R1 reset",
        {result[61:0], done, busy}, 64'd0);
  endtask

  task automatic t_arith();
    run_op(4'h0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 64'd1, 0, "R3 add wrap");
    run_op(4'h0, 1, 0, 64'h1234_5678_FFFF_FFFF, 64'd3, 0, 64'd2, 0, "R4 add32");
    run_op(4'h1, 0, 1, 64'd10, 0, 32'hFFFF_FFFF, 64'd11, 0, "R2 sub sext imm");
    run_op(4'h0, 0, 0, 64'hAAAA_AAAA_0000_0001, 0, 32'hFFFF_FFFF, 64'd0, 0, "R2 add32 imm");
    run_op(4'h2, 1, 1, 64'h1_0000_0001, 64'h1_0000_0001, 0, 64'h2_0000_0001, 0, "R3 mul");
    run_op(4'h2, 1, 0, 64'h1_0001_0000, 64'h1_0000, 0, 64'd0, 0, "R4 mul32 wrap");
  endtask

  task automatic t_logic();
    run_op(4'h4, 1, 1, 64'hF0, 64'h0F, 0, 64'hFF, 0, "R5 or");
    run_op(4'h5, 0, 1, 64'hFFFF_0000_1234_5678, 0, 32'h8000_FFFF, 64'hFFFF_0000_0000_5678, 0, "R5 and imm");
    run_op(4'hA, 1, 0, 64'hFFFF_FFFF_0000_FFFF, 64'hFFFF_0000, 0, 64'h0000_0000_FFFF_FFFF, 0, "R5 xor32");
    run_op(4'hB, 0, 1, 64'h55, 0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 0, "R5 mov64 imm");
    run_op(4'hB, 0, 0, 64'h55, 0, 32'h8000_0000, 64'h0000_0000_8000_0000, 0, "R5 mov32 imm");
  endtask

  task automatic t_shift();
    run_op(4'h6, 1, 1, 64'h8000_0000_0000_0001, 64'd65, 0, 64'd2, 0, "R6 shl mask6");
    run_op(4'h6, 1, 0, 64'h1_8000_0001, 64'd33, 0, 64'd2, 0, "R6 shl32 mask5");
    run_op(4'h7, 1, 1, 64'hF000_0000_0000_0000, 64'd4, 0, 64'h0F00_0000_0000_0000, 0, "R6 shr");
    run_op(4'hC, 1, 1, 64'hF000_0000_0000_0000, 64'd4, 0, 64'hFF00_0000_0000_0000, 0, "R6 sar");
    run_op(4'hC, 0, 0, 64'h8000_0000, 0, 32'd31, 64'h0000_0000_FFFF_FFFF, 0, "R6 sar32");
    run_op(4'h7, 0, 0, 64'hFFFF_FFFF_8000_0000, 0, 32'd31, 64'd1, 0, "R6 shr32");
  endtask

  task automatic t_divide();
    run_op(4'h3, 1, 1, 64'd1000, 64'd7, 0, 64'd142, 64, "R8 div64");
    run_op(4'h9, 1, 1, 64'd1000, 64'd7, 0, 64'd6, 64, "R8 mod64");
    run_op(4'h3, 1, 0, 64'hFFFF_FFFF_0000_0064, 64'h1_0000_0007, 0, 64'd14, 32, "R8 div32");
    run_op(4'h9, 1, 0, 64'hFFFF_FFFF_0000_0064, 64'h1_0000_0007, 0, 64'd2, 32, "R8 mod32");
    run_op(4'h3, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 0, 64'hFFFF_FFFF, 64, "R8 div big");
    run_op(4'h3, 0, 1, 64'd5, 0, 32'hFFFF_FFFF, 64'd0, 64, "R10 div64 sext imm");
    run_op(4'h3, 0, 0, 64'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 64'd1, 32, "R10 div32 unsigned imm");
    run_op(4'h9, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFE, 64'd1, 64, "R10 mod64 imm");
  endtask

  task automatic t_divzero();
    run_op(4'h3, 1, 1, 64'd55, 64'd0, 0, 64'd0, 0, "R9 div64 by zero");
    run_op(4'h9, 1, 1, 64'hDEAD_BEEF_0000_0001, 64'd0, 0, 64'hDEAD_BEEF_0000_0001, 0, "R9 mod64 by zero");
    run_op(4'h9, 1, 0, 64'hDEAD_BEEF_1234_5678, 64'h5_0000_0000, 0, 64'h1234_5678, 0, "R9 mod32 by zero");
    run_op(4'h3, 1, 0, 64'hDEAD_BEEF_1234_5678, 64'h5_0000_0000, 0, 64'd0, 0, "R9 div32 by zero");
  endtask

  task automatic t_swap();
    logic [63:0] v = 64'h1122_3344_5566_7788;
    run_op(4'hD, 1, 0, v, 64'hFF, 32'd16, 64'h8877, 0, "R11 big16");
    run_op(4'hD, 1, 1, v, 64'hFF, 32'd32, 64'h8877_6655, 0, "R11 big32");
    run_op(4'hD, 1, 0, v, 64'hFF, 32'd64, 64'h8877_6655_4433_2211, 0, "R11 big64");
    run_op(4'hD, 0, 1, v, 64'hFF, 32'd16, 64'h7788, 0, "R11 little16");
    run_op(4'hD, 0, 0, v, 64'hFF, 32'd32, 64'h5566_7788, 0, "R11 little32");
    run_op(4'hD, 0, 0, v, 64'hFF, 32'd64, v, 0, "R11 little64");
  endtask

  task automatic t_unlisted();
    run_op(4'h8, 1, 0, 64'hCAFE_F00D_1234_5678, 64'd9, 0, 64'hCAFE_F00D_1234_5678, 0, "R13 code8");
    run_op(4'hF, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd9, 7, 64'h0123_4567_89AB_CDEF, 0, "R13 codeF");
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    op = 4'h3; use_reg = 1; wide = 1; dst = 64'd900; src = 64'd9; imm = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (lat < 10) begin @(negedge clk); lat++; end
    op = 4'h0; dst = 64'd1; src = 64'd1; start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    // R12: the stray add must not complete
    chk(done === 1'b0 && busy === 1'b1, "R12 start ignored", {62'd0, done, busy}, 64'd1);
    while (done !== 1'b1 && lat < 200) begin @(negedge clk); lat++; end
    chk(result === 64'd100, "R12 result", result, 64'd100);
    chk(lat == 64, "R12 latency", 64'(lat), 64'd64);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 0; use_reg = 0; wide = 0; dst = 0; src = 0; imm = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_divide();
    t_divzero();
    t_swap();
    t_unlisted();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule